// File: doc/BRIEF.md
# Split Transmit/Receive Interrupt Status Unit

This block collects interrupt events for an Ethernet MAC and turns them into two level-sensitive interrupt lines, one for transmit and one for receive. The transmit and receive engines raise single-cycle event pulses on a 32-bit event vector. Each pulse is latched into a sticky status register. Transmit flags live in the upper half of that register and receive flags live in the lower half. A 32-bit enable register masks the status.

Each half has one summary bit. The summary bit is itself a status bit. It is recomputed from a fixed subset of its half's event bits, each taken together with its enable bit. An interrupt line is high when its summary bit and that summary bit's own enable bit are both set. Some receive events, such as length/type seen, frame too large and frame too long, are recorded in the status register but never reach the summary.

Software uses a small register port:
- It reads either register.
- It writes the enable register directly.
- It clears status bits by writing ones to the status register.

A soft-reset input wipes both registers.

Top module: `mac_irq_ctrl`

## Requirements
- R1: After rst_n is asserted, the status register, the enable register, tx_irq and rx_irq are all zero.
- R2: An event pulse on any status bit other than bit 0 or bit 16 sets that status bit. The bit stays set until software clears it or a soft reset occurs.
- R3: A write with reg_sel=0 clears every status bit that is 1 in wr_data and leaves the bits that are 0 in wr_data unchanged.
- R4: An event pulse arriving in the same cycle as a write-one-to-clear of the same bit wins, so the bit stays set.
- R5: A write with reg_sel=1 stores all 32 bits of wr_data into the enable register. rd_data shows the status register when reg_sel=0 and the enable register when reg_sel=1, combinationally.
- R6: Status bit 16 (transmit summary) is 1 exactly when at least one of status bits 17 (transmit complete), 18 (transmit descriptor unavailable) or 19 (transmit bus error) is set together with the same-numbered enable bit.
- R7: Status bit 0 (receive summary) is 1 exactly when at least one of status bits 2 (good frame), 5 (receive descriptor unavailable) or 6 (receive bus error) is set together with the same-numbered enable bit.
- R8: Receive bits 1 (length/type seen), 3 (frame too large) and 4 (frame too long) latch but never affect the receive summary, even when enabled. Transmit bits other than 17 to 19 never affect the transmit summary.
- R9: tx_irq is high exactly when status bit 16 and enable bit 16 are both set. rx_irq is high exactly when status bit 0 and enable bit 0 are both set.
- R10: Event pulses and clear writes aimed at bits 0 and 16 have no direct effect. Those bits only follow their summary rule.
- R11: A soft_rst pulse clears the status and enable registers and drives both interrupt lines low. It overrides any event or write in the same cycle.
- R12: Every status, summary, enable and interrupt change becomes visible one clock edge after the event, write or enable change that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous clear of status and enable |
| evt | input | 32 | Single-cycle event pulses, one per status bit |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects status, 1 selects enable (read and write) |
| wr_data | input | 32 | Write data; ones clear status bits when reg_sel=0 |
| rd_data | output | 32 | Read data of the selected register |
| tx_irq | output | 1 | Transmit interrupt level |
| rx_irq | output | 1 | Receive interrupt level |

## Verification
The summaries are driven with three kinds of event:
- events that feed a summary, with their enable bits set;
- the same events with their enable bits clear;
- enabled events that do not feed a summary.

Together these separate a summary that ignores enables from one that listens to the wrong bits. A summary whose own enable bit is clear must still read 1 while its line stays low, which tells the summary apart from the interrupt gating. Collisions of event and clear, of soft reset with event and write, and direct pokes at the summary positions check the priority rules. A sparse random stream of events, writes and soft resets, compared every cycle against a bench model, covers mixtures that the directed cases do not reach.

// File: rtl/mac_irq_ctrl.sv
module mac_irq_ctrl #(
  parameter int DATA_W = 32,
  parameter int RX_SUM_BIT = 0,
  parameter int TX_SUM_BIT = 16,
  parameter logic [DATA_W-1:0] RX_SRC_MASK = 32'h0000_0064,
  parameter logic [DATA_W-1:0] TX_SRC_MASK = 32'h000E_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic [DATA_W-1:0] evt,
  input  logic              wr_en,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              tx_irq,
  output logic              rx_irq
);
  localparam logic [DATA_W-1:0] SUM_MASK =
    (DATA_W'(1) << RX_SUM_BIT) | (DATA_W'(1) << TX_SUM_BIT);

  logic [DATA_W-1:0] stat_q, en_q, stat_d, en_d, clr, kept;
  logic              tx_sum_d, rx_sum_d;

  assign clr  = (wr_en && !reg_sel) ? wr_data : '0;
  assign en_d = soft_rst ? '0 : ((wr_en && reg_sel) ? wr_data : en_q);
  assign kept = ((stat_q & ~clr) | evt) & ~SUM_MASK;

  assign tx_sum_d = |(kept & en_d & TX_SRC_MASK);
  assign rx_sum_d = |(kept & en_d & RX_SRC_MASK);

  always_comb begin
    stat_d = kept;
    stat_d[TX_SUM_BIT] = tx_sum_d;
    stat_d[RX_SUM_BIT] = rx_sum_d;
    if (soft_rst) stat_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
      tx_irq <= 1'b0;
      rx_irq <= 1'b0;
    end else begin
      stat_q <= stat_d;
      en_q   <= en_d;
      tx_irq <= stat_d[TX_SUM_BIT] & en_d[TX_SUM_BIT];
      rx_irq <= stat_d[RX_SUM_BIT] & en_d[RX_SUM_BIT];
    end
  end

  assign rd_data = reg_sel ? en_q : stat_q;
endmodule

module mac_irq_ctrl_chk #(
  parameter int DATA_W = 32,
  parameter int RX_SUM_BIT = 0,
  parameter int TX_SUM_BIT = 16,
  parameter logic [DATA_W-1:0] RX_SRC_MASK = 32'h0000_0064,
  parameter logic [DATA_W-1:0] TX_SRC_MASK = 32'h000E_0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst,
  input logic [DATA_W-1:0] evt,
  input logic              wr_en,
  input logic              reg_sel,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] stat_q,
  input logic [DATA_W-1:0] en_q,
  input logic              tx_irq,
  input logic              rx_irq
);
  localparam logic [DATA_W-1:0] SUM_MASK =
    (DATA_W'(1) << RX_SUM_BIT) | (DATA_W'(1) << TX_SUM_BIT);

  // R2
  evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst |=> ((stat_q & $past(evt & ~SUM_MASK)) == $past(evt & ~SUM_MASK)));
  // R3
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !reg_sel && !soft_rst) |=>
      ((stat_q & $past(wr_data & ~evt & ~SUM_MASK)) == '0));
  // R12
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && !wr_en) |=>
      (((stat_q ^ $past(stat_q)) & ~SUM_MASK & ~$past(evt)) == '0));
  // R6
  tx_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[TX_SUM_BIT] == (|(stat_q & en_q & TX_SRC_MASK)));
  // R7
  rx_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[RX_SUM_BIT] == (|(stat_q & en_q & RX_SRC_MASK)));
  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_irq == (stat_q[TX_SUM_BIT] & en_q[TX_SUM_BIT])) &&
    (rx_irq == (stat_q[RX_SUM_BIT] & en_q[RX_SUM_BIT])));
  // R11
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (stat_q == '0 && en_q == '0 && !tx_irq && !rx_irq));
endmodule

bind mac_irq_ctrl mac_irq_ctrl_chk #(
  .DATA_W(DATA_W), .RX_SUM_BIT(RX_SUM_BIT), .TX_SUM_BIT(TX_SUM_BIT),
  .RX_SRC_MASK(RX_SRC_MASK), .TX_SRC_MASK(TX_SRC_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .evt(evt), .wr_en(wr_en),
  .reg_sel(reg_sel), .wr_data(wr_data), .stat_q(stat_q), .en_q(en_q),
  .tx_irq(tx_irq), .rx_irq(rx_irq)
);

// File: tb/mac_irq_ctrl_tb.sv
module mac_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic [31:0] evt = '0;
  logic        wr_en = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        tx_irq, rx_irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [31:0] m_stat = '0, m_en = '0;

  mac_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .evt(evt), .wr_en(wr_en),
    .reg_sel(reg_sel), .wr_data(wr_data), .rd_data(rd_data),
    .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] f_next_en(input logic [31:0] en, input logic we,
      input logic sel, input logic [31:0] d, input logic sr);
    if (sr) return '0;
    return (we && sel) ? d : en;
  endfunction

  function automatic logic [31:0] f_next_stat(input logic [31:0] st, input logic [31:0] en_new,
      input logic [31:0] ev, input logic we, input logic sel, input logic [31:0] d, input logic sr);
    logic [31:0] b;
    if (sr) return '0;
    b = st;
    if (we && !sel) b = b & ~d;
    b = (b | ev) & ~32'h0001_0001;
    if ((b & en_new & 32'h000E_0000) != 0) b[16] = 1'b1;
    if ((b & en_new & 32'h0000_0064) != 0) b[0] = 1'b1;
    return b;
  endfunction

  task automatic cyc(input logic [31:0] ev, input logic we, input logic sel,
      input logic [31:0] d, input logic sr);
    logic [31:0] ne;
    evt = ev; wr_en = we; reg_sel = sel; wr_data = d; soft_rst = sr;
    @(posedge clk);
    ne = f_next_en(m_en, we, sel, d, sr);
    m_stat = f_next_stat(m_stat, ne, ev, we, sel, d, sr);
    m_en = ne;
    @(negedge clk);
    evt = '0; wr_en = 1'b0; wr_data = '0; soft_rst = 1'b0;
  endtask

  task automatic compare(input string tag);
    reg_sel = 1'b0; #1;
    chk({tag, " status"}, rd_data, m_stat);
    reg_sel = 1'b1; #1;
    chk({tag, " enable"}, rd_data, m_en);
    chk({tag, " tx_irq"}, {31'd0, tx_irq}, {31'd0, m_stat[16] & m_en[16]});
    chk({tag, " rx_irq"}, {31'd0, rx_irq}, {31'd0, m_stat[0] & m_en[0]});
    reg_sel = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 reset");

    cyc(32'h0, 1, 1, 32'hA5A5_5A5A, 0);
    compare("R5 enable write");
    cyc(32'h0, 1, 1, 32'h0001_0001, 0);
    compare("R5 enable rewrite");

    cyc(32'h0000_0008, 0, 0, 0, 0);
    chk("R2 too-large latched", rd_data, 32'h0000_0008);
    cyc(32'h0, 1, 1, 32'h0000_001B, 0);
    compare("R8 non-feeding rx bits enabled");
    chk("R8 rx summary stays low", {31'd0, rx_irq}, 32'd0);

    cyc(32'h0, 1, 1, 32'h0000_0004, 0);
    cyc(32'h0000_0004, 0, 0, 0, 0);
    compare("R7 good frame, summary enable off");
    chk("R9 rx_irq gated by summary enable", {31'd0, rx_irq}, 32'd0);
    reg_sel = 1'b0; #1;
    chk("R7 rx summary set", {31'd0, rd_data[0]}, 32'd1);

    cyc(32'h0, 1, 1, 32'h0000_0005, 0);
    compare("R9 rx_irq on");
    chk("R9 rx_irq high", {31'd0, rx_irq}, 32'd1);

    evt = 32'h0002_0000; reg_sel = 1'b0; #1;
    chk("R12 no change before edge", rd_data, m_stat);
    evt = '0;
    cyc(32'h0002_0000, 0, 0, 0, 0);
    compare("R6 tx complete, not enabled");
    cyc(32'h0, 1, 1, 32'h0003_0005, 0);
    compare("R6 tx summary via enable");
    chk("R6 tx_irq high", {31'd0, tx_irq}, 32'd1);

    cyc(32'h0, 1, 0, 32'h0000_0004, 0);
    compare("R3 clear good frame");
    chk("R7 rx summary dropped", {31'd0, rx_irq}, 32'd0);

    cyc(32'h0000_0040, 1, 0, 32'h0000_0048, 0);
    compare("R4 event beats clear");

    cyc(32'h0, 1, 0, 32'hFFFF_FFFF, 0);
    compare("R3 clear all");
    cyc(32'h0001_0001, 0, 0, 0, 0);
    compare("R10 summary pokes ignored");
    chk("R10 status zero", m_stat, 32'h0);

    cyc(32'h0, 1, 1, 32'hFFFF_FFFF, 0);
    cyc(32'h0004_0020, 0, 0, 0, 0);
    compare("R2 both halves");
    cyc(32'h0, 1, 0, 32'h0001_0001, 0);
    compare("R10 clear of summary bits ignored");
    cyc(32'h0008_0040, 1, 1, 32'hFFFF_FFFF, 1);
    compare("R11 soft reset wins");
    chk("R11 irqs low", {30'd0, tx_irq, rx_irq}, 32'd0);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] ev, d;
      logic we, sel, sr;
      ev  = $urandom & $urandom & $urandom;
      we  = ($urandom % 4) == 0;
      sel = $urandom % 2;
      d   = $urandom;
      sr  = ($urandom % 50) == 0;
      cyc(ev, we, sel, d, sr);
      compare("R12 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule